// File: doc/BRIEF.md
# Descriptor-Fetching Memory Copy Channel

This block is a single memory-to-memory copy channel. Software stores a four-word descriptor in memory, writes its address into the channel's descriptor-pointer register, and then sets the run bit in the control/status register. The channel reads the descriptor through its own memory master port. The descriptor gives the transfer options, where to read, where to write and how many bytes to move. The channel then copies 32-bit words one at a time, reading each one and then writing it.

Each address moves forward by four bytes after every word only when its increment option is set. Otherwise it stays at its start value for the whole transfer, which suits a fixed peripheral data register. When the byte count runs out, the run bit drops. If the descriptor asked for it, a sticky completion flag rises in the same cycle and drives the interrupt output. Software clears the flag by writing 1 to it.

Top module: `cbdma_channel`

## Requirements
- R1: After reset, the control/status register (offset 0x00) reads 0, the descriptor-pointer register (offset 0x04) reads 0, `irq` is low and `mem_req` is low.
- R2: The descriptor-pointer register at offset 0x04 can be written and read back. Writing a word with bit 0 set to offset 0x00 while the channel is idle starts a transfer. Bit 0 of that register then reads 1 until the transfer ends.
- R3: The channel reads the descriptor as four words at the pointer address plus 0, 4, 8 and 12, in that order. These hold, in turn, the options word, the source address, the destination address and the length in bytes.
- R4: In the options word, bit 0 enables the completion interrupt, bit 4 enables destination increment and bit 8 enables source increment. Other bits have no effect.
- R5: A transfer moves ceil(length/4) words. Each word is read from the current source address and then written to the current destination address. A length of 0 moves no data.
- R6: An address whose increment option is set advances by 4 after each word. An address whose option is clear stays at its descriptor value for every word.
- R7: When the last word's write is acknowledged, bit 0 of the control/status register clears. If the interrupt was enabled, bit 2 (the completion flag) sets in the same cycle. `irq` follows bit 2. With the interrupt disabled, bit 2 stays 0.
- R8: Writing a word with bit 2 set to offset 0x00 clears the completion flag. Writing a word with bit 2 clear leaves it unchanged.
- R9: Writing bit 0 of offset 0x00 while a transfer is running is ignored. The running transfer neither restarts nor moves extra words.
- R10: The memory master has at most one request outstanding. It holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until a cycle with `mem_gnt` high. Read data on `mem_rdata` is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside through a synchronizer |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (4) | Register byte offset |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W (32) | Memory byte address |
| mem_wdata | output | DATA_W (32) | Memory write data |
| mem_gnt | input | 1 | Memory acknowledge; completes the current request |
| mem_rdata | input | DATA_W (32) | Memory read data, valid with `mem_gnt` |
| irq | output | 1 | Completion interrupt, equal to the completion flag |

## Verification
The properties assume that the memory returns `mem_gnt` only while `mem_req` is high, and that software keeps the run and clear requests apart from the completion edge. The bench's memory model grants only pending requests, with a latency that cycles between zero and two wait states. The bench writes the flag-clear only after polling shows the channel idle, so a clear never meets a completion edge. The second run request is issued while the descriptor fetch is still in progress, which is when the channel is known to be busy.

// File: rtl/cbdma_pkg.sv
package cbdma_pkg;

  localparam int unsigned REG_CTRL_OFS  = 0;
  localparam int unsigned REG_DPTR_OFS  = 4;

  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_DONE_BIT = 2;

  localparam int unsigned OPT_IRQ_BIT   = 0;
  localparam int unsigned OPT_DINC_BIT  = 4;
  localparam int unsigned OPT_SINC_BIT  = 8;

  localparam int unsigned DESC_WORDS    = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } eng_state_t;

  typedef struct packed {
    logic irq_en;
    logic dst_inc;
    logic src_inc;
  } xfer_opt_t;

endpackage

// File: rtl/cbdma_rst_sync.sv
module cbdma_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cbdma_regs.sv
module cbdma_regs
  import cbdma_pkg::*;
#(
  parameter int unsigned REG_AW = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              done_irq_en_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] dptr_o,
  output logic              flag_o
);

  logic              sel_ctrl, sel_dptr;
  logic              dptr_en;
  logic [ADDR_W-1:0] dptr_q, dptr_d;
  logic              flag_q, flag_d;

  assign sel_ctrl = (addr_i == REG_AW'(REG_CTRL_OFS));
  assign sel_dptr = (addr_i == REG_AW'(REG_DPTR_OFS));

  assign start_o  = wen_i && sel_ctrl && wdata_i[CTRL_RUN_BIT] && !busy_i;
  assign dptr_en  = wen_i && sel_dptr;

  always_comb begin
    dptr_d = dptr_q;
    if (dptr_en) dptr_d = ADDR_W'(wdata_i);
  end

  always_comb begin
    flag_d = flag_q;
    if (done_i && done_irq_en_i)                          flag_d = 1'b1;
    else if (wen_i && sel_ctrl && wdata_i[CTRL_DONE_BIT]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dptr_q <= '0;
      flag_q <= 1'b0;
    end else begin
      dptr_q <= dptr_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[CTRL_RUN_BIT]  = busy_i;
      rdata_o[CTRL_DONE_BIT] = flag_q;
    end else if (sel_dptr) begin
      rdata_o = DATA_W'(dptr_q);
    end
  end

  assign dptr_o = dptr_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/cbdma_engine.sv
module cbdma_engine
  import cbdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dptr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_en_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  localparam int unsigned       STEP_BYTES = DATA_W / 8;
  localparam int unsigned       IDX_W      = $clog2(DESC_WORDS);
  localparam logic [ADDR_W-1:0] ADDR_STEP  = ADDR_W'(STEP_BYTES);
  localparam logic [DATA_W-1:0] LEN_STEP   = DATA_W'(STEP_BYTES);
  localparam logic [IDX_W-1:0]  IDX_OPT    = IDX_W'(0);
  localparam logic [IDX_W-1:0]  IDX_SRC    = IDX_W'(1);
  localparam logic [IDX_W-1:0]  IDX_DST    = IDX_W'(2);

  eng_state_t        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  xfer_opt_t         opt_q, opt_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [DATA_W-1:0] rem_q, rem_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              done_c;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    opt_d   = opt_q;
    base_d  = base_q;
    src_d   = src_q;
    dst_d   = dst_q;
    rem_d   = rem_q;
    buf_d   = buf_q;
    done_c  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_FETCH;
          idx_d   = '0;
          base_d  = dptr_i;
        end
      end
      ST_FETCH: begin
        if (mem_gnt_i) begin
          idx_d = idx_q + IDX_W'(1);
          if (idx_q == IDX_OPT) begin
            opt_d.irq_en  = mem_rdata_i[OPT_IRQ_BIT];
            opt_d.dst_inc = mem_rdata_i[OPT_DINC_BIT];
            opt_d.src_inc = mem_rdata_i[OPT_SINC_BIT];
          end else if (idx_q == IDX_SRC) begin
            src_d = ADDR_W'(mem_rdata_i);
          end else if (idx_q == IDX_DST) begin
            dst_d = ADDR_W'(mem_rdata_i);
          end else begin
            rem_d = mem_rdata_i;
            if (mem_rdata_i == '0) begin
              state_d = ST_IDLE;
              done_c  = 1'b1;
            end else begin
              state_d = ST_READ;
            end
          end
        end
      end
      ST_READ: begin
        if (mem_gnt_i) begin
          buf_d   = mem_rdata_i;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mem_gnt_i) begin
          if (opt_q.src_inc) src_d = src_q + ADDR_STEP;
          if (opt_q.dst_inc) dst_d = dst_q + ADDR_STEP;
          if (rem_q <= LEN_STEP) begin
            rem_d   = '0;
            state_d = ST_IDLE;
            done_c  = 1'b1;
          end else begin
            rem_d   = rem_q - LEN_STEP;
            state_d = ST_READ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      opt_q   <= '0;
      base_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      opt_q   <= opt_d;
      base_q  <= base_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      rem_q   <= rem_d;
      buf_q   <= buf_d;
    end
  end

  always_comb begin
    mem_req_o   = (state_q != ST_IDLE);
    mem_we_o    = (state_q == ST_WRITE);
    mem_wdata_o = buf_q;
    unique case (state_q)
      ST_FETCH: mem_addr_o = base_q + ADDR_W'(idx_q) * ADDR_STEP;
      ST_READ:  mem_addr_o = src_q;
      ST_WRITE: mem_addr_o = dst_q;
      default:  mem_addr_o = '0;
    endcase
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_c;
  assign irq_en_o = opt_q.irq_en;

endmodule

// File: rtl/cbdma_channel.sv
module cbdma_channel
  import cbdma_pkg::*;
#(
  parameter int unsigned REG_AW = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq
);

  logic              rst_sync_n;
  logic              eng_start;
  logic              eng_busy;
  logic              eng_done;
  logic              eng_irq_en;
  logic [ADDR_W-1:0] dptr;

  cbdma_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cbdma_regs #(
    .REG_AW (REG_AW),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .wen_i         (reg_wen),
    .addr_i        (reg_addr),
    .wdata_i       (reg_wdata),
    .rdata_o       (reg_rdata),
    .busy_i        (eng_busy),
    .done_i        (eng_done),
    .done_irq_en_i (eng_irq_en),
    .start_o       (eng_start),
    .dptr_o        (dptr),
    .flag_o        (irq)
  );

  cbdma_engine #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_engine (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (eng_start),
    .dptr_i      (dptr),
    .busy_o      (eng_busy),
    .done_o      (eng_done),
    .irq_en_o    (eng_irq_en),
    .mem_req_o   (mem_req),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_gnt_i   (mem_gnt),
    .mem_rdata_i (mem_rdata)
  );

endmodule

// File: rtl/cbdma_channel_sva.sv
module cbdma_channel_sva #(
  parameter int unsigned REG_AW = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wen,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              busy,
  input logic              irq_en,
  input logic              irq,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_gnt
);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_flag_only_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(busy));

  assert_end_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && irq_en) |-> irq);

  assert_start_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wen && (reg_addr == REG_AW'(0)) && reg_wdata[0]));

endmodule

bind cbdma_channel cbdma_channel_sva #(
  .REG_AW (REG_AW),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wen   (reg_wen),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .busy      (eng_busy),
  .irq_en    (eng_irq_en),
  .irq       (irq),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_gnt   (mem_gnt)
);

// File: tb/cbdma_channel_bench.sv
module cbdma_channel_bench;

  localparam int MEM_WORDS = 128;
  localparam int SRC_IDX   = 8;    // byte 0x020
  localparam int DST_IDX   = 32;   // byte 0x080
  localparam int DESC_IDX  = 64;   // byte 0x100

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wen;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt;
  logic [31:0] mem_rdata;
  logic        irq;

  always #5 clk = ~clk;

  cbdma_channel u_cbdma_channel (
    .clk(clk), .rst_n(rst_n),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq)
  );

  logic [31:0] mem     [MEM_WORDS];
  logic [31:0] exp_mem [MEM_WORDS];
  int          wait_cnt;
  int          txn_cnt;
  int          wr_count;
  logic        l_we;
  logic [31:0] l_addr, l_wdata;
  int          n_checks;
  int          n_fail;
  logic        finished;

  // Memory model: grants at the falling edge after 0..2 wait states.
  always @(negedge clk) begin
    if (mem_gnt) begin
      if (l_we) begin
        mem[l_addr[8:2]] = l_wdata;
        wr_count = wr_count + 1;
      end
      txn_cnt  = txn_cnt + 1;
      wait_cnt = 0;
    end
    mem_gnt = 1'b0;
    if (mem_req) begin
      if (wait_cnt >= (txn_cnt % 3)) begin
        mem_gnt   = 1'b1;
        mem_rdata = mem[mem_addr[8:2]];
        l_we      = mem_we;
        l_addr    = mem_addr;
        l_wdata   = mem_wdata;
      end else begin
        wait_cnt = wait_cnt + 1;
      end
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, expv);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen   = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wen   = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run_case(input int sinc, input int dinc, input int ien, input int len, input int id);
    int          nw;
    int          mism;
    int          first_bad;
    int          polls;
    logic [31:0] rd;
    nw = (len + 3) / 4;
    for (int i = 0; i < MEM_WORDS; i++)
      mem[i] = 32'hC0DE0000 + 32'(i) * 32'h00010003 + 32'(id) * 32'h01000000;
    // Options word (R4): bit0 irq, bit4 dst inc, bit8 src inc; also junk bits elsewhere.
    mem[DESC_IDX]     = 32'h0000_6060 | (32'(sinc) << 8) | (32'(dinc) << 4) | 32'(ien);
    mem[DESC_IDX + 1] = 32'(SRC_IDX * 4);
    mem[DESC_IDX + 2] = 32'(DST_IDX * 4);
    mem[DESC_IDX + 3] = 32'(len);
    for (int i = 0; i < MEM_WORDS; i++) exp_mem[i] = mem[i];
    for (int k = 0; k < nw; k++)
      exp_mem[DST_IDX + (dinc != 0 ? k : 0)] = mem[SRC_IDX + (sinc != 0 ? k : 0)];
    wr_count = 0;

    reg_write(4'h4, 32'h100);
    reg_read(4'h4, rd);
    check(rd == 32'h100, "R2 pointer readback", rd, 32'h100);
    reg_write(4'h0, 32'h1);
    reg_read(4'h0, rd);
    check(rd[0] == 1'b1, "R2 run bit set after start", rd, 32'h1);
    reg_write(4'h0, 32'h1);  // R9: repeat start while busy
    polls = 0;
    rd    = 32'h1;
    while (rd[0] && polls < 2000) begin
      reg_read(4'h0, rd);
      polls++;
    end
    check(rd == (ien != 0 ? 32'h4 : 32'h0), "R7 ctrl/status after end", rd, ien != 0 ? 32'h4 : 32'h0);
    check(irq == (ien != 0), "R7 irq follows flag", 32'(irq), 32'(ien != 0));
    check(wr_count == nw, "R5 R9 word writes", 32'(wr_count), 32'(nw));
    mism      = 0;
    first_bad = -1;
    for (int i = 0; i < MEM_WORDS; i++)
      if (mem[i] !== exp_mem[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    // R3 R4 R6 R10: descriptor order, options, address stepping, handshake all reflect here.
    check(mism == 0, "R3 R4 R6 R10 memory image",
          first_bad < 0 ? 32'h0 : mem[first_bad], first_bad < 0 ? 32'h0 : exp_mem[first_bad]);
    if (ien != 0) begin
      reg_write(4'h0, 32'h0);
      reg_read(4'h0, rd);
      check(rd == 32'h4, "R8 zero write keeps flag", rd, 32'h4);
      reg_write(4'h0, 32'h4);
      reg_read(4'h0, rd);
      check(rd == 32'h0 && irq == 1'b0, "R8 clear by writing 1", rd, 32'h0);
    end
  endtask

  initial begin
    finished = 1'b0;
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int          id;
    int          lens [6];
    n_checks  = 0;
    n_fail    = 0;
    wait_cnt  = 0;
    txn_cnt   = 0;
    wr_count  = 0;
    mem_gnt   = 1'b0;
    mem_rdata = '0;
    l_we      = 1'b0;
    l_addr    = '0;
    l_wdata   = '0;
    reg_wen   = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    rst_n     = 1'b0;
    lens      = '{0, 4, 8, 20, 30, 32};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    reg_read(4'h0, rd);
    check(rd == 32'h0, "R1 ctrl/status reset", rd, 32'h0);
    reg_read(4'h4, rd);
    check(rd == 32'h0, "R1 pointer reset", rd, 32'h0);
    check(irq == 1'b0 && mem_req == 1'b0, "R1 irq and mem_req idle", {30'h0, irq, mem_req}, 32'h0);

    id = 0;
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 2; d++)
        for (int e = 0; e < 2; e++)
          for (int l = 0; l < 6; l++) begin
            run_case(s, d, e, lens[l], id);
            id++;
          end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule